// File: doc/BRIEF.md
# Phase-Alignable Sample Clock Divider

This block derives a slower sample clock from a fast input clock by integer division by 1, 2 or 4. Downstream logic samples on the rising edge of the divided clock. Several copies of the block, or the block and a host device, can be brought into phase with each other by raising a shared alignment request input. Two alignment methods are offered. The slip method holds the divider for one input-clock cycle, so its pattern lags by one cycle. The zero method forces the divider phase back to zero, which puts the next divided rising edge at a known cycle.

The request is sampled on input-clock rising edges and edge-detected. A small arming state machine then counts towards the edge on which the alignment is applied. It has two states. `ARM_IDLE` moves to `ARM_COUNT` on a detected request edge (transition *arm*). `ARM_COUNT` moves back to `ARM_IDLE` when its countdown reaches zero (transition *fire*). A fresh request edge in `ARM_COUNT` reloads the countdown (transition *rearm*). Whenever the divide ratio is 1, the machine is forced to `ARM_IDLE` (transition *bypass*). By default the alignment acts on the third input-clock rising edge after the request rises. The parameter `SYNC_LAT` sets that count, with a minimum of 3.

Top module: `clkdiv_sync`

## Requirements
- R1: While `rst_n` is low, the divider phase is 0, `clk_out` is low for ratios 2 and 4, and `sync_done` is low.
- R2: With `ratio_sel`=2'b01 (divide by 2), the phase counts 0,1,0,1 on successive input edges after reset release. `clk_out` is high exactly when the phase is 1.
- R3: With divide by 4, the phase counts 0..3 and wraps. `clk_out` is high exactly in phases 2 and 3.
- R4: With `ratio_sel`=2'b00 (divide by 1), `clk_out` equals `clk_in`, and `sync_align` has no effect (no `sync_done` pulse).
- R5: Call the first input rising edge that samples `sync_align` high edge 1. The alignment is applied on edge `SYNC_LAT` (3 by default). `sync_done` is high for exactly the one input cycle that follows that edge.
- R6: With `sync_mode`=0 (slip), the phase does not advance on the application edge. Afterwards the divided pattern continues one input cycle late.
- R7: With `sync_mode`=1 (zero), the phase is 0 after the application edge. With the default latency, the next `clk_out` rising edge therefore follows edge 4 (divide by 2) or edge 5 (divide by 4).
- R8: Holding `sync_align` high produces only one alignment. A new alignment needs the input to go low and then high again.
- R9: A new request edge that is detected while a countdown is in progress restarts the full `SYNC_LAT` delay from that new edge. The earlier pending alignment is dropped.
- R10: `ratio_sel` encoding: 2'b00 divides by 1, 2'b01 by 2, and both 2'b10 and 2'b11 by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Divide ratio select (see R10) |
| sync_mode | input | 1 | Alignment method: 0 slip, 1 zero phase |
| sync_align | input | 1 | Alignment request, acts on its rising edge |
| clk_out | output | 1 | Divided sample clock |
| sync_done | output | 1 | One-cycle pulse after an alignment is applied |

## Verification
The hardest case to reach is the restart of a countdown that is already running. At the default latency of three edges, the request cannot fall and rise again before the pending alignment fires, so the restart can never be seen. The bench therefore adds a second instance with a five-edge latency. It drives that instance with a high-low-high request whose second rise lands mid-count, then checks that the strobe and the zeroed phase follow the second rise rather than the first. Every offset of the request against the divider phase is also swept, for both ratios and both methods.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;

    // Largest division is 2**MAX_LOG.
    localparam int unsigned MAX_LOG = 2;
    localparam int unsigned PH_W    = MAX_LOG;

    typedef enum logic {
        SYNC_SLIP = 1'b0,
        SYNC_ZERO = 1'b1
    } sync_mode_e;

    typedef enum logic [1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2
    } div_mode_e;

    typedef enum logic {
        ARM_IDLE  = 1'b0,
        ARM_COUNT = 1'b1
    } arm_state_e;

    // Select codes above the largest ratio saturate to it.
    function automatic div_mode_e decode_ratio(input logic [1:0] sel);
        if (sel > 2'(MAX_LOG)) begin
            return div_mode_e'(2'(MAX_LOG));
        end
        return div_mode_e'(sel);
    endfunction

endpackage

// File: rtl/cds_arm.sv
module cds_arm
    import clkdiv_sync_pkg::*;
#(
    parameter int unsigned LAT_EDGES = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic req_i,
    output logic fire_o
);

    localparam int unsigned CNT_W = $clog2(LAT_EDGES);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LAT_EDGES - 3);

    logic             smp_q;
    logic             smp_d;
    logic             rise;
    arm_state_e       state_q;
    arm_state_e       state_n;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    // Request sampler and edge detector
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            smp_q <= 1'b0;
            smp_d <= 1'b0;
        end else begin
            smp_q <= req_i;
            smp_d <= smp_q;
        end
    end

    assign rise = smp_q & ~smp_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ARM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next-state logic: bypass, arm / rearm, count, fire
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!en_i) begin
            state_n = ARM_IDLE;
            cnt_n   = '0;
        end else if (rise) begin
            state_n = ARM_COUNT;
            cnt_n   = RELOAD;
        end else begin
            unique case (state_q)
                ARM_IDLE: begin
                    state_n = ARM_IDLE;
                end
                ARM_COUNT: begin
                    if (cnt_q == '0) begin
                        state_n = ARM_IDLE;
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
                default: state_n = ARM_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            ARM_IDLE:  fire_o = 1'b0;
            ARM_COUNT: fire_o = en_i && !rise && (cnt_q == '0);
            default:   fire_o = 1'b0;
        endcase
    end

    // A held-high request never re-arms an idle machine.
    p_held_no_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_q && smp_d && state_q == ARM_IDLE) |=> (state_q == ARM_IDLE));

    // A detected edge always loads the full countdown.
    p_arm_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise && en_i) |=> (state_q == ARM_COUNT && cnt_q == RELOAD));

    // Bypass keeps the machine quiet.
    p_bypass_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (state_q == ARM_IDLE));

endmodule

// File: rtl/cds_phase.sv
module cds_phase
    import clkdiv_sync_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  div_mode_e  div_i,
    input  sync_mode_e mode_i,
    input  logic       fire_i,
    output logic       level_o
);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_n;
    logic [PH_W-1:0] last;

    assign last = PH_W'((32'd1 << div_i) - 32'd1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_n;
        end
    end

    always_comb begin
        if (div_i == DIV_BY1) begin
            phase_n = '0;
        end else if (fire_i && mode_i == SYNC_ZERO) begin
            phase_n = '0;
        end else if (fire_i) begin
            phase_n = (phase_q > last) ? '0 : phase_q;
        end else begin
            phase_n = (phase_q >= last) ? '0 : phase_q + 1'b1;
        end
    end

    // High during the upper half of the cycle.
    always_comb begin
        unique case (div_i)
            DIV_BY1: level_o = 1'b0;
            DIV_BY2: level_o = phase_q[0];
            default: level_o = phase_q[PH_W-1];
        endcase
    end

    p_phase_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(last) |-> (phase_q <= last));

    p_zero_applied_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && mode_i == SYNC_ZERO && div_i != DIV_BY1) |=> (phase_q == '0));

    p_slip_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && mode_i == SYNC_SLIP && div_i != DIV_BY1 && phase_q <= last)
        |=> (phase_q == $past(phase_q)));

endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync
    import clkdiv_sync_pkg::*;
#(
    parameter int unsigned SYNC_LAT = 3
) (
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic [1:0] ratio_sel,
    input  logic       sync_mode,
    input  logic       sync_align,
    output logic       clk_out,
    output logic       sync_done
);

    div_mode_e  div_mode;
    sync_mode_e mode;
    logic       fire;
    logic       level;
    logic       done_q;

    assign div_mode = decode_ratio(ratio_sel);
    assign mode     = sync_mode_e'(sync_mode);

    cds_arm #(
        .LAT_EDGES(SYNC_LAT)
    ) u_arm (
        .clk_i (clk_in),
        .rst_ni(rst_n),
        .en_i  (div_mode != DIV_BY1),
        .req_i (sync_align),
        .fire_o(fire)
    );

    cds_phase u_phase (
        .clk_i  (clk_in),
        .rst_ni (rst_n),
        .div_i  (div_mode),
        .mode_i (mode),
        .fire_i (fire),
        .level_o(level)
    );

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= fire;
        end
    end

    assign sync_done = done_q;
    assign clk_out   = (div_mode == DIV_BY1) ? clk_in : level;

    p_strobe_single_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        sync_done |=> !sync_done);

    p_bypass_no_strobe_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        (div_mode == DIV_BY1 && $past(div_mode == DIV_BY1)) |-> !sync_done);

endmodule

// File: tb/clkdiv_sync_tb.sv
module clkdiv_sync_tb;

    logic       clk    = 1'b0;
    logic       rst_n  = 1'b1;
    logic [1:0] sel    = 2'd1;
    logic       mode   = 1'b0;
    logic       sync_a = 1'b0;
    logic       sync_b = 1'b0;
    logic       clk_out;
    logic       done;
    logic       clk_out_l;
    logic       done_l;

    int  errs     = 0;
    int  total    = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    clkdiv_sync u_dut (
        .clk_in(clk), .rst_n(rst_n), .ratio_sel(sel), .sync_mode(mode),
        .sync_align(sync_a), .clk_out(clk_out), .sync_done(done)
    );

    clkdiv_sync #(.SYNC_LAT(5)) u_dut_long (
        .clk_in(clk), .rst_n(rst_n), .ratio_sel(sel), .sync_mode(mode),
        .sync_align(sync_b), .clk_out(clk_out_l), .sync_done(done_l)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int ratio_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic int lvl(input int ph, input int n);
        return ((ph % n) >= (n / 2)) ? 1 : 0;
    endfunction

    task automatic start(input logic [1:0] s, input logic m);
        step();
        rst_n  = 1'b0;
        sel    = s;
        mode   = m;
        sync_a = 1'b0;
        sync_b = 1'b0;
        step();
        step();
        if (s != 2'd0) chk("R1 clk_out low in reset", clk_out, 0);
        chk("R1 sync_done low in reset", done, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        // R4: bypass follows clk_in, request ignored
        start(2'd0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step();
            #1 chk("R4 clk_out follows low", clk_out, 0);
            @(posedge clk);
            #1 chk("R4 clk_out follows high", clk_out, 1);
        end
        step();
        sync_a = 1'b1;
        for (int k = 0; k < 6; k++) begin
            step();
            chk("R4 no strobe in bypass", done, 0);
        end
        sync_a = 1'b0;

        // Sweep ratios (incl. R10 code 2'b11), methods and request offsets
        for (int s = 1; s <= 3; s++) begin
            for (int m = 0; m <= 1; m++) begin
                for (int off = 0; off <= ratio_of(2'(s)) + 1; off++) begin
                    int n;
                    n = ratio_of(2'(s));
                    start(2'(s), 1'(m));
                    for (int k = 1; k <= off; k++) begin
                        step();
                        chk(s == 1 ? "R2 free run" : (s == 3 ? "R10 code3 free run" : "R3 free run"),
                            clk_out, lvl(k, n));
                    end
                    sync_a = 1'b1;
                    for (int j = 1; j <= 2 * n + 4; j++) begin
                        int ph;
                        step();
                        if (j < 3)       ph = off + j;
                        else if (m == 1) ph = j - 3;
                        else             ph = off + j - 1;
                        chk(m == 1 ? "R7 zero phase" : "R6 slip", clk_out, lvl(ph, n));
                        chk(j > 3 ? "R8 held request" : "R5 strobe timing", done, (j == 3) ? 1 : 0);
                    end
                    sync_a = 1'b0;
                end
            end
        end

        // R8: re-arm needs a low-to-high transition
        start(2'd1, 1'b1);
        step();
        sync_a = 1'b1;
        for (int k = 0; k < 6; k++) step();
        sync_a = 1'b0;
        step();
        sync_a = 1'b1;
        for (int j = 1; j <= 5; j++) begin
            step();
            chk("R8 rearm after low", done, (j == 3) ? 1 : 0);
        end
        sync_a = 1'b0;

        // R9 baseline: five-edge latency
        start(2'd2, 1'b1);
        sync_b = 1'b1;
        for (int j = 1; j <= 7; j++) begin
            step();
            chk("R9 baseline latency", done_l, (j == 5) ? 1 : 0);
        end
        sync_b = 1'b0;

        // R9: second edge mid-count restarts the delay
        start(2'd2, 1'b1);
        step();
        sync_b = 1'b1;
        step();
        sync_b = 1'b0;
        step();
        sync_b = 1'b1;
        step();
        sync_b = 1'b0;
        for (int j = 4; j <= 10; j++) begin
            step();
            chk("R9 restart strobe", done_l, (j == 7) ? 1 : 0);
            if (j >= 7) chk("R9 restart phase", clk_out_l, lvl(j - 7, 4));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            errs++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

endmodule